// File: doc/BRIEF.md
# Video Processor Host Register Interface

This block sits between the host CPU bus and a tile-based video processor. The CPU presents a chip select, a write enable, an address and a byte of write data. The block decodes eight byte-wide registers from the three low address bits, so the same eight registers appear again every eight bytes across the whole window the chip select covers. It keeps the write-side state that the rest of the video chip needs: the control byte, the mask byte, the sprite-memory pointer, the two scroll offsets and the 14-bit video-memory pointer. It sends these out as decoded fields.

Two of the registers, scroll and address, take two bytes each. A single toggle that both share says which byte comes next, and reading the status register sends the toggle back to the first byte. Accesses to the sprite-data and video-data ports move their pointers forward, and the block raises one-cycle strobes so that the memories, which live elsewhere, can act on the access. A counter started at reset blocks control-register writes for a set number of cycles. The sprite pointer is forced to zero during the sprite-fetch portion of each active scanline.

Top module: `vpu_host_regs`

## Requirements
- R1: The register is chosen by `cpu_addr[2:0]` alone, with 0 control, 1 mask, 2 status, 3 sprite pointer, 4 sprite data, 5 scroll, 6 address and 7 data. The higher address bits have no effect.
- R2: `nt_base` equals 0x2000 plus 0x400 times control bits [1:0].
- R3: `vram_step` is 1 when control bit 2 is 0 and 32 when it is 1. Each read or write of register 7 adds `vram_step` to `vram_addr`, modulo 0x4000, in the cycle after the access.
- R4: A write to register 5 loads `scroll_x` when `write_toggle` is 0 and `scroll_y` when it is 1. Each such write inverts `write_toggle`.
- R5: A write to register 6 with `write_toggle` 0 latches data bits [5:0] as the upper pointer bits, and bits 7:6 are dropped. A write with `write_toggle` 1 sets `vram_addr` to {latched bits, data}. Each such write inverts the same toggle that R4 uses.
- R6: A read of register 2 clears `write_toggle` and pulses `status_rd`.
- R7: A write to register 3 loads `oam_addr`. A write to register 4 pulses `oam_we` and adds 1 to `oam_addr`, modulo 256.
- R8: While `line_active` is 1 and `dot` is between 257 and 320 inclusive, `oam_addr` becomes 0 on the next clock. This overrides any CPU write in the same cycle.
- R9: For the first LOCK_CYCLES clocks after reset, writes to register 0 are ignored. After that window, they take effect.
- R10: Each assertion of `cpu_cs` is one access, taken in its first cycle, however long `cpu_cs` stays high.
- R11: `render_en` is 1 exactly when mask bit 3 or mask bit 4 is set.
- R12: After reset, all register state and `write_toggle` are 0, `nt_base` is 0x2000 and `vram_step` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_cs | input | 1 | Chip select; one access per assertion |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | ADDR_W | CPU address; only bits [2:0] are decoded |
| cpu_wdata | input | 8 | Write data |
| line_active | input | 1 | Current scanline is pre-render or visible |
| dot | input | DOT_W | Dot position on the scanline |
| nt_base | output | 14 | Base name-table address |
| vram_step | output | 6 | Video pointer step (1 or 32) |
| spr_tbl_hi | output | 1 | Control bit 3: sprite pattern table upper half |
| bg_tbl_hi | output | 1 | Control bit 4: background pattern table upper half |
| spr_tall | output | 1 | Control bit 5: tall sprites |
| ext_drive | output | 1 | Control bit 6: drive the colour expansion pins |
| vblank_irq_en | output | 1 | Control bit 7: interrupt at vertical blank |
| gray | output | 1 | Mask bit 0: monochrome |
| show_bg_left | output | 1 | Mask bit 1: background in left 8 pixels |
| show_spr_left | output | 1 | Mask bit 2: sprites in left 8 pixels |
| show_bg | output | 1 | Mask bit 3: background on |
| show_spr | output | 1 | Mask bit 4: sprites on |
| tint | output | 3 | Mask bits 7:5: colour emphasis |
| render_en | output | 1 | Background or sprites enabled |
| oam_addr | output | 8 | Sprite memory pointer |
| scroll_x | output | 8 | Horizontal scroll |
| scroll_y | output | 8 | Vertical scroll |
| vram_addr | output | 14 | Video memory pointer |
| write_toggle | output | 1 | 0 next byte is first, 1 next byte is second |
| oam_we | output | 1 | Sprite-data write strobe, at pointer `oam_addr` |
| vram_wr | output | 1 | Data-port write strobe, at pointer `vram_addr` |
| vram_rd | output | 1 | Data-port read strobe, at pointer `vram_addr` |
| status_rd | output | 1 | Status read strobe |

## Verification
The bound checker tests the following on every cycle: the toggle flips on each scroll or address write and clears after a status read; data-port accesses move the video pointer by the selected step; sprite-data writes step the sprite pointer unless the fetch zone overrides them; the fetch zone forces the pointer to zero; and control writes during the lockout leave the control byte unchanged. Some behaviour shows only in the bench's sequences. Mirrored addresses reaching the same register, the high and low address bytes combining into one pointer, wrap-around at 0x4000 and at 256, a long chip-select pulse counting once, and the exact decoded field values all need a run of accesses with known results.

// File: rtl/vpu_host_pkg.sv
package vpu_host_pkg;

    localparam int VADDR_W = 14;
    localparam int HI_W    = VADDR_W - 8;
    localparam int STEP_W  = 6;

    typedef enum logic [2:0] {
        RS_CTRL = 3'd0,
        RS_MASK = 3'd1,
        RS_STAT = 3'd2,
        RS_OAMA = 3'd3,
        RS_OAMD = 3'd4,
        RS_SCRL = 3'd5,
        RS_ADDR = 3'd6,
        RS_DATA = 3'd7
    } host_reg_e;

    typedef struct packed {
        logic [7:0]         ctrl;
        logic [7:0]         mask;
        logic [7:0]         oam_addr;
        logic [7:0]         scroll_x;
        logic [7:0]         scroll_y;
        logic [HI_W-1:0]    addr_hi;
        logic [VADDR_W-1:0] vram_addr;
        logic               toggle;
    } host_state_t;

endpackage

// File: rtl/vpu_host_decode.sv
module vpu_host_decode
    import vpu_host_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_cs,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              acc_wr,
    output logic              acc_rd,
    output host_reg_e         sel
);

    logic cs_d, cs_q;
    logic take;
    logic unused_hi_bits;

    // Only the low three bits choose a register; the rest mirror.
    assign unused_hi_bits = ^cpu_addr[ADDR_W-1:3];
    assign sel            = host_reg_e'(cpu_addr[2:0]);

    always_comb begin
        cs_d = cpu_cs;
        take = cpu_cs & ~cs_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= 1'b0;
        else        cs_q <= cs_d;
    end

    assign acc_wr = take & cpu_we;
    assign acc_rd = take & ~cpu_we;

endmodule

// File: rtl/vpu_host_lockout.sv
module vpu_host_lockout #(
    parameter int LOCK_CYCLES = 30000
) (
    input  logic clk,
    input  logic rst_n,
    output logic locked
);

    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        locked = (cnt_q < CNT_W'(LOCK_CYCLES));
        cnt_d  = locked ? cnt_q + 1'b1 : cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/vpu_host_oam_zone.sv
module vpu_host_oam_zone #(
    parameter int DOT_W     = 9,
    parameter int CLR_FIRST = 257,
    parameter int CLR_LAST  = 320
) (
    input  logic             line_active,
    input  logic [DOT_W-1:0] dot,
    output logic             oam_clr
);

    localparam logic [DOT_W-1:0] LO = DOT_W'(CLR_FIRST);
    localparam logic [DOT_W-1:0] HI = DOT_W'(CLR_LAST);

    assign oam_clr = line_active && (dot >= LO) && (dot <= HI);

endmodule

// File: rtl/vpu_host_regs.sv
module vpu_host_regs
    import vpu_host_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int LOCK_CYCLES = 30000,
    parameter int DOT_W       = 9,
    parameter int CLR_FIRST   = 257,
    parameter int CLR_LAST    = 320
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_cs,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [7:0]         cpu_wdata,
    input  logic               line_active,
    input  logic [DOT_W-1:0]   dot,
    output logic [VADDR_W-1:0] nt_base,
    output logic [STEP_W-1:0]  vram_step,
    output logic               spr_tbl_hi,
    output logic               bg_tbl_hi,
    output logic               spr_tall,
    output logic               ext_drive,
    output logic               vblank_irq_en,
    output logic               gray,
    output logic               show_bg_left,
    output logic               show_spr_left,
    output logic               show_bg,
    output logic               show_spr,
    output logic [2:0]         tint,
    output logic               render_en,
    output logic [7:0]         oam_addr,
    output logic [7:0]         scroll_x,
    output logic [7:0]         scroll_y,
    output logic [VADDR_W-1:0] vram_addr,
    output logic               write_toggle,
    output logic               oam_we,
    output logic               vram_wr,
    output logic               vram_rd,
    output logic               status_rd
);

    localparam logic [VADDR_W-1:0] NT_ORIGIN = VADDR_W'(14'h2000);
    localparam int                 NT_SHIFT  = 10;

    host_state_t st_d, st_q;
    host_reg_e   sel;
    logic        acc_wr, acc_rd;
    logic        locked;
    logic        oam_clr;
    logic [VADDR_W-1:0] step_w;

    vpu_host_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_cs   (cpu_cs),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .acc_wr   (acc_wr),
        .acc_rd   (acc_rd),
        .sel      (sel)
    );

    vpu_host_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .locked (locked)
    );

    vpu_host_oam_zone #(
        .DOT_W     (DOT_W),
        .CLR_FIRST (CLR_FIRST),
        .CLR_LAST  (CLR_LAST)
    ) u_zone (
        .line_active (line_active),
        .dot         (dot),
        .oam_clr     (oam_clr)
    );

    assign vram_step = st_q.ctrl[2] ? STEP_W'(32) : STEP_W'(1);
    assign step_w    = VADDR_W'(vram_step);

    always_comb begin
        st_d = st_q;
        if (acc_wr) begin
            unique case (sel)
                RS_CTRL: if (!locked) st_d.ctrl = cpu_wdata;
                RS_MASK: st_d.mask = cpu_wdata;
                RS_OAMA: st_d.oam_addr = cpu_wdata;
                RS_OAMD: st_d.oam_addr = st_q.oam_addr + 8'd1;
                RS_SCRL: begin
                    if (!st_q.toggle) st_d.scroll_x = cpu_wdata;
                    else              st_d.scroll_y = cpu_wdata;
                    st_d.toggle = ~st_q.toggle;
                end
                RS_ADDR: begin
                    if (!st_q.toggle) st_d.addr_hi   = cpu_wdata[HI_W-1:0];
                    else              st_d.vram_addr = {st_q.addr_hi, cpu_wdata};
                    st_d.toggle = ~st_q.toggle;
                end
                RS_DATA: st_d.vram_addr = st_q.vram_addr + step_w;
                default: ;
            endcase
        end
        if (acc_rd) begin
            if (sel == RS_STAT) st_d.toggle    = 1'b0;
            if (sel == RS_DATA) st_d.vram_addr = st_q.vram_addr + step_w;
        end
        if (oam_clr) st_d.oam_addr = 8'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nt_base       = NT_ORIGIN | (VADDR_W'(st_q.ctrl[1:0]) << NT_SHIFT);
    assign spr_tbl_hi    = st_q.ctrl[3];
    assign bg_tbl_hi     = st_q.ctrl[4];
    assign spr_tall      = st_q.ctrl[5];
    assign ext_drive     = st_q.ctrl[6];
    assign vblank_irq_en = st_q.ctrl[7];
    assign gray          = st_q.mask[0];
    assign show_bg_left  = st_q.mask[1];
    assign show_spr_left = st_q.mask[2];
    assign show_bg       = st_q.mask[3];
    assign show_spr      = st_q.mask[4];
    assign tint          = st_q.mask[7:5];
    assign render_en     = st_q.mask[3] | st_q.mask[4];
    assign oam_addr      = st_q.oam_addr;
    assign scroll_x      = st_q.scroll_x;
    assign scroll_y      = st_q.scroll_y;
    assign vram_addr     = st_q.vram_addr;
    assign write_toggle  = st_q.toggle;

    assign oam_we    = acc_wr & (sel == RS_OAMD);
    assign vram_wr   = acc_wr & (sel == RS_DATA);
    assign vram_rd   = acc_rd & (sel == RS_DATA);
    assign status_rd = acc_rd & (sel == RS_STAT);

endmodule

// File: rtl/vpu_host_regs_chk.sv
module vpu_host_regs_chk #(
    parameter int LOCK_CYCLES = 30000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_wr,
    input logic [2:0]  sel,
    input logic        oam_clr,
    input logic [7:0]  ctrl,
    input logic [7:0]  oam_addr,
    input logic [13:0] vram_addr,
    input logic [5:0]  vram_step,
    input logic        write_toggle,
    input logic        oam_we,
    input logic        vram_wr,
    input logic        vram_rd,
    input logic        status_rd
);

    localparam int CW = $clog2(LOCK_CYCLES + 1);
    logic [CW-1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           since_rst <= '0;
        else if (since_rst < CW'(LOCK_CYCLES)) since_rst <= since_rst + 1'b1;
    end

    a_r4_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && (sel == 3'd5 || sel == 3'd6)) |=> (write_toggle != $past(write_toggle)));

    a_r6_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |=> !write_toggle);

    a_r3_vram_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_wr || vram_rd) |=> (vram_addr == 14'($past(vram_addr) + 14'($past(vram_step)))));

    a_r7_oam_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (oam_we && !oam_clr) |=> (oam_addr == 8'($past(oam_addr) + 8'd1)));

    a_r8_oam_zero: assert property (@(posedge clk) disable iff (!rst_n)
        oam_clr |=> (oam_addr == 8'd0));

    a_r9_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && sel == 3'd0 && since_rst < CW'(LOCK_CYCLES)) |=> $stable(ctrl));

endmodule

bind vpu_host_regs vpu_host_regs_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_wr       (acc_wr),
    .sel          (sel),
    .oam_clr      (oam_clr),
    .ctrl         (st_q.ctrl),
    .oam_addr     (oam_addr),
    .vram_addr    (vram_addr),
    .vram_step    (vram_step),
    .write_toggle (write_toggle),
    .oam_we       (oam_we),
    .vram_wr      (vram_wr),
    .vram_rd      (vram_rd),
    .status_rd    (status_rd)
);

// File: tb/sim_vpu_host_regs.sv
`timescale 1ns/1ps
module sim_vpu_host_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_cs = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        line_active = 1'b0;
    logic [8:0]  dot = '0;

    logic [13:0] nt_base, vram_addr;
    logic [5:0]  vram_step;
    logic        spr_tbl_hi, bg_tbl_hi, spr_tall, ext_drive, vblank_irq_en;
    logic        gray, show_bg_left, show_spr_left, show_bg, show_spr, render_en;
    logic [2:0]  tint;
    logic [7:0]  oam_addr, scroll_x, scroll_y;
    logic        write_toggle, oam_we, vram_wr, vram_rd, status_rd;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    vpu_host_regs #(.LOCK_CYCLES(40)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_cs(cpu_cs), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .line_active(line_active), .dot(dot),
        .nt_base(nt_base), .vram_step(vram_step),
        .spr_tbl_hi(spr_tbl_hi), .bg_tbl_hi(bg_tbl_hi), .spr_tall(spr_tall),
        .ext_drive(ext_drive), .vblank_irq_en(vblank_irq_en),
        .gray(gray), .show_bg_left(show_bg_left), .show_spr_left(show_spr_left),
        .show_bg(show_bg), .show_spr(show_spr), .tint(tint), .render_en(render_en),
        .oam_addr(oam_addr), .scroll_x(scroll_x), .scroll_y(scroll_y),
        .vram_addr(vram_addr), .write_toggle(write_toggle),
        .oam_we(oam_we), .vram_wr(vram_wr), .vram_rd(vram_rd), .status_rd(status_rd)
    );

    // obs: 0 toggle, 1 scroll_x, 2 scroll_y, 3 vram_addr, 4 nt_base,
    //      5 oam_addr, 6 render_en, 7 vram_step
    typedef struct packed {
        logic [15:0] a;
        logic        we;
        logic [7:0]  d;
        logic [2:0]  obs;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{16'h2005, 1'b1, 8'h7B, 3'd1, 16'h007B, 4'd4},  // R4 first scroll byte
        '{16'h3FFD, 1'b1, 8'h2C, 3'd2, 16'h002C, 4'd1},  // R1 mirror, R4 second byte
        '{16'h2006, 1'b1, 8'hFF, 3'd0, 16'h0001, 4'd5},  // R5 high byte, toggle set
        '{16'h2A0E, 1'b1, 8'h34, 3'd3, 16'h3F34, 4'd5},  // R5 14-bit pointer, R1 mirror
        '{16'h2007, 1'b1, 8'h11, 3'd3, 16'h3F35, 4'd3},  // R3 step 1
        '{16'h2000, 1'b1, 8'h07, 3'd4, 16'h2C00, 4'd2},  // R2 table 3
        '{16'h3000, 1'b0, 8'h00, 3'd7, 16'h0020, 4'd3},  // R3 step 32, ctrl read no effect
        '{16'h2007, 1'b0, 8'h00, 3'd3, 16'h3F55, 4'd3},  // R3 read advances
        '{16'h2005, 1'b1, 8'h10, 3'd0, 16'h0001, 4'd4},  // R4 toggle set
        '{16'h2002, 1'b0, 8'h00, 3'd0, 16'h0000, 4'd6},  // R6 status read clears
        '{16'h2005, 1'b1, 8'h22, 3'd1, 16'h0022, 4'd6},  // R6 next write is first byte
        '{16'h2003, 1'b1, 8'hFE, 3'd5, 16'h00FE, 4'd7},  // R7 pointer load
        '{16'h2004, 1'b1, 8'hAA, 3'd5, 16'h00FF, 4'd7},  // R7 data write increments
        '{16'h200C, 1'b1, 8'hBB, 3'd5, 16'h0000, 4'd7},  // R7 wrap, R1 mirror
        '{16'h2001, 1'b1, 8'h18, 3'd6, 16'h0001, 4'd11}, // R11 both
        '{16'h2001, 1'b1, 8'h08, 3'd6, 16'h0001, 4'd11}, // R11 background only
        '{16'h2001, 1'b1, 8'h10, 3'd6, 16'h0001, 4'd11}, // R11 sprites only
        '{16'h2001, 1'b1, 8'h06, 3'd6, 16'h0000, 4'd11}, // R11 neither
        '{16'h200A, 1'b0, 8'h00, 3'd0, 16'h0000, 4'd6},  // R6 via mirror
        '{16'h2006, 1'b1, 8'h3F, 3'd0, 16'h0001, 4'd5},  // R5
        '{16'h2006, 1'b1, 8'hF0, 3'd3, 16'h3FF0, 4'd5},  // R5
        '{16'h2007, 1'b1, 8'h00, 3'd3, 16'h0010, 4'd3},  // R3 wrap at 0x4000
        '{16'h2000, 1'b1, 8'h01, 3'd4, 16'h2400, 4'd2},  // R2 table 1
        '{16'h2007, 1'b0, 8'h00, 3'd3, 16'h0011, 4'd3}   // R3 back to step 1
    };

    function automatic logic [15:0] observe(input logic [2:0] k);
        case (k)
            3'd0: observe = {15'd0, write_toggle};
            3'd1: observe = {8'd0, scroll_x};
            3'd2: observe = {8'd0, scroll_y};
            3'd3: observe = {2'd0, vram_addr};
            3'd4: observe = {2'd0, nt_base};
            3'd5: observe = {8'd0, oam_addr};
            3'd6: observe = {15'd0, render_en};
            default: observe = {10'd0, vram_step};
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] a, input logic w, input logic [7:0] d,
                          input int hold);
        @(negedge clk);
        cpu_cs = 1'b1; cpu_we = w; cpu_addr = a; cpu_wdata = d;
        repeat (hold) @(negedge clk);
        cpu_cs = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 toggle",   {15'd0, write_toggle}, 16'h0000);
        check("R12 vram",     {2'd0, vram_addr},     16'h0000);
        check("R12 oam",      {8'd0, oam_addr},      16'h0000);
        check("R12 scroll",   {scroll_x, scroll_y},  16'h0000);
        check("R12 nt_base",  {2'd0, nt_base},       16'h2000);
        check("R12 step",     {10'd0, vram_step},    16'h0001);
        check("R12 render",   {15'd0, render_en},    16'h0000);

        // R9 control write during lockout is dropped
        access(16'h2000, 1'b1, 8'hFF, 1);
        check("R9 locked nt_base", {2'd0, nt_base}, 16'h2000);
        check("R9 locked irq",     {15'd0, vblank_irq_en}, 16'h0000);
        repeat (60) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].a, VEC[i].we, VEC[i].d, 1);
            check($sformatf("R%0d vec %0d", VEC[i].req, i), observe(VEC[i].obs), VEC[i].exp);
        end

        // R9 after the window, full control byte lands
        access(16'h2000, 1'b1, 8'hB8, 1);
        check("R9 open fields", {11'd0, vblank_irq_en, ext_drive, spr_tall, bg_tbl_hi, spr_tbl_hi},
              16'h0017);
        access(16'h2000, 1'b1, 8'h00, 1);

        // R10 held chip select counts once
        access(16'h2005, 1'b1, 8'h55, 5);
        check("R10 held scroll_x", {8'd0, scroll_x}, 16'h0055);
        check("R10 held toggle",   {15'd0, write_toggle}, 16'h0001);
        access(16'h2002, 1'b0, 8'h00, 1);
        access(16'h2007, 1'b1, 8'h00, 4);
        check("R10 held data step", {2'd0, vram_addr}, 16'h0012);

        // R8 sprite pointer forced to zero in the fetch zone
        access(16'h2003, 1'b1, 8'h40, 1);
        @(negedge clk); line_active = 1'b1; dot = 9'd256;
        @(negedge clk);
        check("R8 dot 256 kept", {8'd0, oam_addr}, 16'h0040);
        dot = 9'd257;
        @(negedge clk);
        check("R8 dot 257 zero", {8'd0, oam_addr}, 16'h0000);
        dot = 9'd300;
        access(16'h2003, 1'b1, 8'h12, 1);
        check("R8 overrides write", {8'd0, oam_addr}, 16'h0000);
        dot = 9'd321;
        access(16'h2003, 1'b1, 8'h12, 1);
        check("R8 dot 321 free", {8'd0, oam_addr}, 16'h0012);
        line_active = 1'b0; dot = 9'd300;
        access(16'h2004, 1'b1, 8'h99, 1);
        check("R8 inactive line R7 inc", {8'd0, oam_addr}, 16'h0013);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule